// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks where each of the two ALU operands of an in-order five-stage integer pipeline comes from. It compares the two source register numbers of the instruction entering execute with the destination register, valid flag and write flag of the two younger pipeline registers (execute/memory and memory/write-back). For each operand it produces a select code and the chosen operand value. The value is the register file read, the execute/memory result or the memory/write-back result. A dependent instruction issued right behind its producer therefore runs without a stall.

The register file is assumed to write in the first half of a cycle and read in the second. An instruction three slots behind its producer reads the new value straight from the register file, so there is no bypass path from the write-back stage. Loads carry a one-instruction architectural delay. The block inserts no interlock. An instruction in the load's delay slot that names the load's destination receives whatever the execute/memory register holds. Hazards where a write comes after a write, or a write comes after a read, cannot arise in this pipe, and no logic is spent on them.

Top module: `operandBypassUnit`

## Requirements
- R1: When neither later stage holds a live write to an operand's source register, that operand's select is 2'b00 and the operand equals its register file read value.
- R2: When the execute/memory stage holds a live write (valid=1, write=1, destination nonzero) whose destination equals the operand's source, the select is 2'b01 and the operand equals the execute/memory result.
- R3: When only the memory/write-back stage holds a live write matching the source, the select is 2'b10 and the operand equals the memory/write-back result.
- R4: When both stages hold live matching writes, the younger execute/memory result wins (select 2'b01).
- R5: A source register of 0 always gives select 2'b00 and an operand of zero, even when a stage writes register 0 or the register file read value is nonzero.
- R6: A stage whose valid flag or write flag is 0 never supplies a forwarded value, whatever its destination.
- R7: Operands A and B are resolved independently, so one instruction may take each operand from a different source in the same cycle.
- R8: The select code 2'b11 is never produced.
- R9: For four consecutive consumers of one producer's destination, the selects are 2'b01, 2'b10, 2'b00 and 2'b00 in that order, and all four operands carry the producer's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the bound checker |
| rstN | input | 1 | Active-low reset, used only by the bound checker |
| srcRegA | input | REG_W | First source register number of the instruction in execute |
| srcRegB | input | REG_W | Second source register number of the instruction in execute |
| exMemValid | input | 1 | Execute/memory register holds a real instruction |
| exMemWrite | input | 1 | That instruction writes a register |
| exMemDest | input | REG_W | Its destination register number |
| exMemResult | input | DATA_W | Result held in the execute/memory register |
| memWbValid | input | 1 | Memory/write-back register holds a real instruction |
| memWbWrite | input | 1 | That instruction writes a register |
| memWbDest | input | REG_W | Its destination register number |
| memWbResult | input | DATA_W | Result held in the memory/write-back register |
| rfDataA | input | DATA_W | Register file read value for srcRegA |
| rfDataB | input | DATA_W | Register file read value for srcRegB |
| operandA | output | DATA_W | Selected first ALU operand |
| operandB | output | DATA_W | Selected second ALU operand |
| selA | output | 2 | Select code for operand A (00 file, 01 exec/mem, 10 mem/wb) |
| selB | output | 2 | Select code for operand B, same coding |

## Verification
The assertions assume that the inputs are settled when the clock rises and that the register file read values belong to the presented source numbers. Nothing is assumed about whether the two stage destinations are equal or differ. The random stimulus draws register numbers from a four-entry range that includes register 0, so matches, double matches and writes to register 0 are frequent. The valid and write flags are drawn independently, so dead producers with matching destinations also occur. Inputs change only on falling edges, which keeps them stable across each rising edge where the properties sample.

// File: rtl/bypassPkg.sv
package bypassPkg;
  localparam int NUM_OPS = 2;

  // Operand source codes
  localparam logic [1:0] SEL_RF    = 2'b00;
  localparam logic [1:0] SEL_EXMEM = 2'b01;
  localparam logic [1:0] SEL_MEMWB = 2'b10;

  // Strobes from control to datapath, one lane per operand
  typedef struct packed {
    logic [NUM_OPS-1:0][1:0] sel;
    logic [NUM_OPS-1:0]      forceZero;
  } bypassStrobes_t;
endpackage

// File: rtl/bypassControl.sv
module bypassControl
  import bypassPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_OPS-1:0][REG_W-1:0] srcRegs,
  input  logic                          exMemValid,
  input  logic                          exMemWrite,
  input  logic [REG_W-1:0]              exMemDest,
  input  logic                          memWbValid,
  input  logic                          memWbWrite,
  input  logic [REG_W-1:0]              memWbDest,
  output bypassStrobes_t                strobes
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  // A stage may feed a value only if it really writes a nonzero register
  logic exMemLive;
  logic memWbLive;
  assign exMemLive = exMemValid && exMemWrite && (exMemDest != ZERO_REG);
  assign memWbLive = memWbValid && memWbWrite && (memWbDest != ZERO_REG);

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_lane
    logic hitExMem;
    logic hitMemWb;
    logic isZero;
    assign isZero   = (srcRegs[op] == ZERO_REG);
    assign hitExMem = exMemLive && (exMemDest == srcRegs[op]);
    assign hitMemWb = memWbLive && (memWbDest == srcRegs[op]);

    always_comb begin
      strobes.forceZero[op] = isZero;
      if (isZero)        strobes.sel[op] = SEL_RF;
      else if (hitExMem) strobes.sel[op] = SEL_EXMEM;  // younger wins
      else if (hitMemWb) strobes.sel[op] = SEL_MEMWB;
      else               strobes.sel[op] = SEL_RF;
    end
  end
endmodule

// File: rtl/bypassDatapath.sv
module bypassDatapath
  import bypassPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  bypassStrobes_t                 strobes,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] rfData,
  input  logic [DATA_W-1:0]              exMemResult,
  input  logic [DATA_W-1:0]              memWbResult,
  output logic [NUM_OPS-1:0][DATA_W-1:0] operands
);
  for (genvar op = 0; op < NUM_OPS; op++) begin : g_mux
    always_comb begin
      unique case (strobes.sel[op])
        SEL_EXMEM: operands[op] = exMemResult;
        SEL_MEMWB: operands[op] = memWbResult;
        default:   operands[op] = strobes.forceZero[op] ? '0 : rfData[op];
      endcase
    end
  end
endmodule

// File: rtl/operandBypassUnit.sv
module operandBypassUnit
  import bypassPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  srcRegA,
  input  logic [REG_W-1:0]  srcRegB,
  input  logic              exMemValid,
  input  logic              exMemWrite,
  input  logic [REG_W-1:0]  exMemDest,
  input  logic [DATA_W-1:0] exMemResult,
  input  logic              memWbValid,
  input  logic              memWbWrite,
  input  logic [REG_W-1:0]  memWbDest,
  input  logic [DATA_W-1:0] memWbResult,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  output logic [DATA_W-1:0] operandA,
  output logic [DATA_W-1:0] operandB,
  output logic [1:0]        selA,
  output logic [1:0]        selB
);
  bypassStrobes_t                 strobes;
  logic [NUM_OPS-1:0][REG_W-1:0]  srcRegs;
  logic [NUM_OPS-1:0][DATA_W-1:0] rfData;
  logic [NUM_OPS-1:0][DATA_W-1:0] operands;

  assign srcRegs = {srcRegB, srcRegA};
  assign rfData  = {rfDataB, rfDataA};

  bypassControl #(.REG_W(REG_W)) u_ctrl (
    .srcRegs   (srcRegs),
    .exMemValid(exMemValid),
    .exMemWrite(exMemWrite),
    .exMemDest (exMemDest),
    .memWbValid(memWbValid),
    .memWbWrite(memWbWrite),
    .memWbDest (memWbDest),
    .strobes   (strobes)
  );

  bypassDatapath #(.DATA_W(DATA_W)) u_dp (
    .strobes    (strobes),
    .rfData     (rfData),
    .exMemResult(exMemResult),
    .memWbResult(memWbResult),
    .operands   (operands)
  );

  assign operandA = operands[0];
  assign operandB = operands[1];
  assign selA     = strobes.sel[0];
  assign selB     = strobes.sel[1];
endmodule

// File: rtl/bypassChecker.sv
module bypassChecker #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_W-1:0]  srcRegA,
  input logic              exMemValid,
  input logic              exMemWrite,
  input logic [REG_W-1:0]  exMemDest,
  input logic [DATA_W-1:0] exMemResult,
  input logic              memWbValid,
  input logic              memWbWrite,
  input logic [REG_W-1:0]  memWbDest,
  input logic [DATA_W-1:0] memWbResult,
  input logic [DATA_W-1:0] rfDataA,
  input logic [DATA_W-1:0] operandA,
  input logic [1:0]        selA,
  input logic [1:0]        selB
);
  logic srcNz;
  logic exHit;
  logic wbHit;
  assign srcNz = (srcRegA != '0);
  assign exHit = srcNz && exMemValid && exMemWrite && (exMemDest == srcRegA);
  assign wbHit = srcNz && memWbValid && memWbWrite && (memWbDest == srcRegA);

  // R1
  rf_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcNz && !exHit && !wbHit) |-> (selA == 2'b00 && operandA == rfDataA));
  // R2
  exmem_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    exHit |-> (selA == 2'b01 && operandA == exMemResult));
  // R3
  memwb_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbHit && !exHit) |-> (selA == 2'b10 && operandA == memWbResult));
  // R5
  zero_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !srcNz |-> (selA == 2'b00 && operandA == '0));
  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selA != 2'b11) && (selB != 2'b11));
endmodule

bind operandBypassUnit bypassChecker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srcRegA    (srcRegA),
  .exMemValid (exMemValid),
  .exMemWrite (exMemWrite),
  .exMemDest  (exMemDest),
  .exMemResult(exMemResult),
  .memWbValid (memWbValid),
  .memWbWrite (memWbWrite),
  .memWbDest  (memWbDest),
  .memWbResult(memWbResult),
  .rfDataA    (rfDataA),
  .operandA   (operandA),
  .selA       (selA),
  .selB       (selB)
);

// File: tb/operandBypassUnit_test.sv
module operandBypassUnit_test;
  localparam int DATA_W = 32;
  localparam int REG_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [REG_W-1:0]  srcRegA = '0, srcRegB = '0;
  logic              exMemValid = 1'b0, exMemWrite = 1'b0;
  logic [REG_W-1:0]  exMemDest = '0;
  logic [DATA_W-1:0] exMemResult = '0;
  logic              memWbValid = 1'b0, memWbWrite = 1'b0;
  logic [REG_W-1:0]  memWbDest = '0;
  logic [DATA_W-1:0] memWbResult = '0;
  logic [DATA_W-1:0] rfDataA = '0, rfDataB = '0;
  logic [DATA_W-1:0] operandA, operandB;
  logic [1:0]        selA, selB;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  operandBypassUnit #(.DATA_W(DATA_W), .REG_W(REG_W)) uut (.*);

  // Expected select from the requirements
  function automatic logic [1:0] expSel(logic [REG_W-1:0] src);
    logic ex, wb;
    ex = exMemValid && exMemWrite && exMemDest == src;
    wb = memWbValid && memWbWrite && memWbDest == src;
    if (src == '0) return 2'b00;
    if (ex) return 2'b01;
    if (wb) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] expOp(logic [REG_W-1:0] src, logic [DATA_W-1:0] rf);
    case (expSel(src))
      2'b01:   return exMemResult;
      2'b10:   return memWbResult;
      default: return (src == '0) ? '0 : rf;
    endcase
  endfunction

  function automatic string reqTag(logic [REG_W-1:0] src);
    logic ex, wb;
    ex = exMemValid && exMemWrite && exMemDest == src;
    wb = memWbValid && memWbWrite && memWbDest == src;
    if (src == '0) return "R5";
    if (ex && wb) return "R4";
    if (ex) return "R2";
    if (wb) return "R3";
    if ((exMemDest == src) || (memWbDest == src)) return "R6";
    return "R1";
  endfunction

  task automatic check(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Sample 2 ns after inputs change at the falling edge
  task automatic checkAll(string forceTag);
    string ta, tb;
    #2;
    ta = (forceTag != "") ? forceTag : reqTag(srcRegA);
    tb = (forceTag != "") ? forceTag : reqTag(srcRegB);
    check(ta, "selA", {30'd0, selA}, {30'd0, expSel(srcRegA)});
    check(tb, "selB", {30'd0, selB}, {30'd0, expSel(srcRegB)});
    check(ta, "operandA", operandA, expOp(srcRegA, rfDataA));
    check(tb, "operandB", operandB, expOp(srcRegB, rfDataB));
    check("R8", "codes", {30'd0, selA == 2'b11 || selB == 2'b11}, '0);
  endtask

  task automatic setStages(logic ev, logic ew, logic [REG_W-1:0] ed, logic [DATA_W-1:0] er,
                           logic mv, logic mw, logic [REG_W-1:0] md, logic [DATA_W-1:0] mr);
    exMemValid = ev; exMemWrite = ew; exMemDest = ed; exMemResult = er;
    memWbValid = mv; memWbWrite = mw; memWbDest = md; memWbResult = mr;
  endtask

  initial begin
    #200000;
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // Reset state: idle inputs select the register file (R1)
    @(negedge clk);
    checkAll("R1");
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R2 / R7: A from exec/mem, B from mem/wb simultaneously
    @(negedge clk);
    srcRegA = 5'd3; srcRegB = 5'd9; rfDataA = 32'h1111; rfDataB = 32'h2222;
    setStages(1, 1, 5'd3, 32'hAAAA, 1, 1, 5'd9, 32'hBBBB);
    checkAll("R7");

    // R4: both stages write the same register
    @(negedge clk);
    srcRegA = 5'd4; srcRegB = 5'd4;
    setStages(1, 1, 5'd4, 32'hC0DE, 1, 1, 5'd4, 32'hDEAD);
    checkAll("R4");

    // R5: register 0 with producers writing 0 and nonzero file value
    @(negedge clk);
    srcRegA = 5'd0; srcRegB = 5'd0; rfDataA = 32'h7777; rfDataB = 32'h8888;
    setStages(1, 1, 5'd0, 32'h1, 1, 1, 5'd0, 32'h2);
    checkAll("R5");

    // R6: matching destinations but dead producers
    @(negedge clk);
    srcRegA = 5'd6; srcRegB = 5'd6; rfDataA = 32'h6060; rfDataB = 32'h6161;
    setStages(0, 1, 5'd6, 32'h1, 1, 0, 5'd6, 32'h2);
    checkAll("R6");

    // R9: producer writes r5 := 0x5555, followed by four consumers of r5
    begin
      logic [DATA_W-1:0] regFile5;
      regFile5 = 32'h0;
      srcRegA = 5'd5; srcRegB = 5'd2; rfDataB = 32'h0202;
      // consumer 1: producer in exec/mem
      @(negedge clk);
      rfDataA = regFile5;
      setStages(1, 1, 5'd5, 32'h5555, 1, 1, 5'd8, 32'h0808);
      checkAll("R9");
      check("R9", "c1 sel", {30'd0, selA}, 32'd1);
      // consumer 2: producer in mem/wb, consumer 1 (dest 7) in exec/mem
      @(negedge clk);
      setStages(1, 1, 5'd7, 32'h7070, 1, 1, 5'd5, 32'h5555);
      checkAll("R9");
      check("R9", "c2 sel", {30'd0, selA}, 32'd2);
      // consumer 3: producer wrote in first half, file read returns it
      @(negedge clk);
      regFile5 = 32'h5555;
      rfDataA = regFile5;
      setStages(1, 1, 5'd10, 32'hA0A0, 1, 1, 5'd7, 32'h7070);
      checkAll("R9");
      check("R9", "c3 op", operandA, 32'h5555);
      // consumer 4
      @(negedge clk);
      setStages(1, 1, 5'd11, 32'hB0B0, 1, 1, 5'd10, 32'hA0A0);
      checkAll("R9");
      check("R9", "c4 op", operandA, 32'h5555);
    end

    // Random mix over a small register range
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      srcRegA = REG_W'($urandom % 4); srcRegB = REG_W'($urandom % 4);
      rfDataA = $urandom; rfDataB = $urandom;
      setStages(($urandom % 4) != 0, ($urandom % 4) != 0, REG_W'($urandom % 4), $urandom,
                ($urandom % 4) != 0, ($urandom % 4) != 0, REG_W'($urandom % 4), $urandom);
      checkAll("");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule